// File: doc/BRIEF.md
# Timer Capture/Compare Interrupt Flags

This block is the status side of a free-running timer. It holds a counter that advances on every clock and either wraps at its all-ones value or returns to zero at a selectable TOP value. From that counter it raises four sticky interrupt flags: a capture flag, two compare-match flags (channels A and B) and an overflow flag. Each flag drives its own interrupt request through a per-flag enable bit.

Software loads the two compare values, the capture/TOP value, the enable bits and the counting mode through a single-cycle register write port. The same port clears flags when a one is written to a flag's bit position. An interrupt controller can clear a flag with a one-cycle acknowledge pulse when it services that flag's interrupt. The current counter value and capture register are driven out so that the surrounding logic can read them. The forced-compare strobes are accepted but never raise a flag.

Top module: `tmr_flag_unit`

## Requirements
- R1: After reset the counter, both compare registers, the capture register, the mode, all four flags, all enable bits and all interrupt requests are zero.
- R2: The counter advances by one every clock. The mode is written at address 5, bits 1:0. Mode 0 (and the unused code 3) wraps from all-ones to zero. Mode 1 returns to zero in the clock after the counter equals compare register A (address 0). Mode 2 returns to zero in the clock after the counter equals the capture register (address 2). In modes 1 and 2 a counter already above TOP runs on to all-ones and wraps.
- R3: The compare A flag is set in the cycle after the counter equals compare register A (address 0). The compare B flag is set in the cycle after the counter equals compare register B (address 1).
- R4: A pulse on `foc_a` or `foc_b` never sets a compare flag and does not disturb the counter.
- R5: The overflow flag is set in the cycle after the counter wraps from all-ones to zero, in every mode. A return to zero at a TOP below all-ones does not set it.
- R6: In modes 0, 1 and 3, a `cap_evt` pulse copies the counter into the capture register and sets the capture flag in the next cycle. When a capture and a write to address 2 fall in the same cycle, the capture wins.
- R7: In mode 2, `cap_evt` is ignored and the capture register keeps its value. The capture flag is set in the cycle after the counter equals the capture register.
- R8: A one on `irq_ack` clears a flag in the next cycle. Bit 3 clears capture, bit 2 clears compare A, bit 1 clears compare B and bit 0 clears overflow.
- R9: A write to address 3 clears each flag whose status bit position holds a one in the written data. Writing a zero leaves that flag unchanged.
- R10: When a flag's set event and any clear of that flag fall in the same cycle, the flag ends set.
- R11: `status_o` carries the capture flag at bit 5, compare A at bit 4, compare B at bit 3 and overflow at bit 2. Bits 7:6 and 1:0 read zero.
- R12: Each `irq_o` bit is its flag ANDed with an enable bit. The enable bits are written at address 4, in the same bit positions as `status_o`. `irq_o` and `flags_o` use the same order as `irq_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 cmp A, 1 cmp B, 2 capture/TOP, 3 flag clear, 4 enables, 5 mode) |
| wr_data | input | CNT_W | Write data |
| cap_evt | input | 1 | Capture event pulse |
| foc_a | input | 1 | Forced compare strobe, channel A |
| foc_b | input | 1 | Forced compare strobe, channel B |
| irq_ack | input | 4 | Per-flag interrupt acknowledge pulses |
| cnt_o | output | CNT_W | Counter value |
| cap_o | output | CNT_W | Capture/TOP register value |
| flags_o | output | 4 | Flags {capture, cmp A, cmp B, overflow} |
| status_o | output | 8 | Status register image |
| irq_o | output | 4 | Interrupt requests, same order as flags_o |

## Verification
Assertions check on every cycle how the counter steps, wraps and returns at TOP. They also check that compare and capture flags rise exactly one cycle after the matching count, that a set beats a same-cycle clear, that an acknowledge or write-one clears a flag when nothing sets it, that forced strobes never raise a compare flag, and that a capture copies the count. Only the bench scenarios can show the reset image, the register address map, the status bit layout, enable gating of the requests, and that a clear-on-compare period never raises overflow. The bench compares every output against its own cycle model on each clock, across directed phases and a long random phase with a narrow counter.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_CLR_A   = 2'd1,
    MODE_CLR_CAP = 2'd2,
    MODE_SPARE   = 2'd3
  } tmr_mode_e;

  localparam int FLAG_N   = 4;
  localparam int F_OVF    = 0;
  localparam int F_CMPB   = 1;
  localparam int F_CMPA   = 2;
  localparam int F_CAP    = 3;
  localparam int STAT_W   = 8;
  localparam int STAT_LSB = 2;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_CMPA = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CAP  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd5;

  // Sticky flag update: clears apply first, sets override them.
  function automatic logic [FLAG_N-1:0] flag_update(
    input logic [FLAG_N-1:0] cur,
    input logic [FLAG_N-1:0] set,
    input logic [FLAG_N-1:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [STAT_W-1:0] status_pack(input logic [FLAG_N-1:0] f);
    logic [STAT_W-1:0] s;
    s = '0;
    s[STAT_LSB +: FLAG_N] = f;
    return s;
  endfunction

endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic                 cap_load,
  input  logic [CNT_W-1:0]     cap_value,
  output logic [CNT_W-1:0]     cmp_a,
  output logic [CNT_W-1:0]     cmp_b,
  output logic [CNT_W-1:0]     cap_q,
  output logic [FLAG_N-1:0]    en_q,
  output tmr_mode_e            mode_q,
  output logic [FLAG_N-1:0]    w1c_mask
);

  localparam int CMP_N = 2;

  logic [CNT_W-1:0] cmp_q [CMP_N];

  // Compare registers sit at consecutive addresses from ADDR_CMPA.
  for (genvar g = 0; g < CMP_N; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_CMPA + ADDR_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cmp_q[g] <= '0;
      else if (wr_en && wr_addr == MY_ADDR) cmp_q[g] <= wr_data;
    end
  end

  assign cmp_a = cmp_q[0];
  assign cmp_b = cmp_q[1];

  // Capture copy has priority over a software load in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cap_q <= '0;
    else if (cap_load)                       cap_q <= cap_value;
    else if (wr_en && wr_addr == ADDR_CAP)   cap_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             en_q <= '0;
    else if (wr_en && wr_addr == ADDR_EN)   en_q <= wr_data[STAT_LSB +: FLAG_N];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             mode_q <= MODE_FREE;
    else if (wr_en && wr_addr == ADDR_MODE) mode_q <= tmr_mode_e'(wr_data[1:0]);
  end

  assign w1c_mask = (wr_en && wr_addr == ADDR_CLR) ? wr_data[STAT_LSB +: FLAG_N] : '0;

  // R6: a capture load lands in the register on the next cycle
  a_r6_cap_copy: assert property (@(posedge clk) disable iff (!rst_n)
    cap_load |=> cap_q == $past(cap_value));

  // R9: a clear write never alters the enable bits
  a_r9_clr_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_CLR) |=> $stable(en_q));

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tmr_mode_e            mode_i,
  input  logic [CNT_W-1:0]     cmp_a_i,
  input  logic [CNT_W-1:0]     cmp_b_i,
  input  logic [CNT_W-1:0]     cap_i,
  input  logic                 cap_evt_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [FLAG_N-1:0]    set_o,
  output logic                 cap_load_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] top_of(
    input tmr_mode_e m,
    input logic [CNT_W-1:0] a,
    input logic [CNT_W-1:0] c
  );
    case (m)
      MODE_CLR_A:   return a;
      MODE_CLR_CAP: return c;
      default:      return CNT_MAX;
    endcase
  endfunction

  // Returns to zero at TOP; a count above TOP runs on to the natural wrap.
  function automatic logic [CNT_W-1:0] count_next(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] top
  );
    return (cur == top) ? '0 : cur + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_w;
  logic             hit_max;
  logic             hit_a;
  logic             hit_b;
  logic             hit_cap;
  logic             cap_is_top;

  assign top_w      = top_of(mode_i, cmp_a_i, cap_i);
  assign hit_max    = (cnt_q == CNT_MAX);
  assign hit_a      = (cnt_q == cmp_a_i);
  assign hit_b      = (cnt_q == cmp_b_i);
  assign hit_cap    = (cnt_q == cap_i);
  assign cap_is_top = (mode_i == MODE_CLR_CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= count_next(cnt_q, top_w);
  end

  assign set_o[F_OVF]  = hit_max;
  assign set_o[F_CMPB] = hit_b;
  assign set_o[F_CMPA] = hit_a;
  assign set_o[F_CAP]  = cap_is_top ? hit_cap : cap_evt_i;
  assign cap_load_o    = cap_evt_i && !cap_is_top;
  assign cnt_o         = cnt_q;

  // R2: all-ones always rolls over to zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == '0));

  // R2: clear-on-compare-A returns to zero after reaching compare A
  a_r2_clr_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_CLR_A && cnt_q == cmp_a_i) |=> (cnt_q == '0));

  // R2: capture-as-TOP returns to zero after reaching the capture value
  a_r2_clr_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_CLR_CAP && cnt_q == cap_i) |=> (cnt_q == '0));

  // R2: away from every return point the count steps by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != CNT_MAX && !(mode_i == MODE_CLR_A && cnt_q == cmp_a_i)
     && !(mode_i == MODE_CLR_CAP && cnt_q == cap_i))
    |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/tmr_flags.sv
`timescale 1ns/1ps
module tmr_flags
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] set_i,
  input  logic [FLAG_N-1:0] ack_i,
  input  logic [FLAG_N-1:0] w1c_i,
  input  logic [FLAG_N-1:0] en_i,
  output logic [FLAG_N-1:0] flags_o,
  output logic [FLAG_N-1:0] irq_o
);

  logic [FLAG_N-1:0] clr_w;
  logic [FLAG_N-1:0] nxt_w;

  assign clr_w = ack_i | w1c_i;
  assign nxt_w = flag_update(flags_o, set_i, clr_w);

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_o[i] <= 1'b0;
      else        flags_o[i] <= nxt_w[i];
    end

    // R10: a set event wins over any clear in the same cycle
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_o[i]);

    // R8: an acknowledge with no set event clears the flag
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[i] && !set_i[i]) |=> !flags_o[i]);

    // R9: a write-one with no set event clears the flag
    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_i[i] && !set_i[i]) |=> !flags_o[i]);

    // R8: without set or clear a flag holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[i] && !ack_i[i] && !w1c_i[i]) |=> $stable(flags_o[i]));
  end

  assign irq_o = flags_o & en_i;

endmodule

// File: rtl/tmr_flag_unit.sv
`timescale 1ns/1ps
module tmr_flag_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic                 cap_evt,
  input  logic                 foc_a,
  input  logic                 foc_b,
  input  logic [FLAG_N-1:0]    irq_ack,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [CNT_W-1:0]     cap_o,
  output logic [FLAG_N-1:0]    flags_o,
  output logic [STAT_W-1:0]    status_o,
  output logic [FLAG_N-1:0]    irq_o
);

  logic [CNT_W-1:0]  cmp_a_w;
  logic [CNT_W-1:0]  cmp_b_w;
  logic [CNT_W-1:0]  cap_w;
  logic [FLAG_N-1:0] en_w;
  logic [FLAG_N-1:0] w1c_w;
  logic [FLAG_N-1:0] set_w;
  logic              cap_load_w;
  tmr_mode_e         mode_w;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cap_load  (cap_load_w),
    .cap_value (cnt_o),
    .cmp_a     (cmp_a_w),
    .cmp_b     (cmp_b_w),
    .cap_q     (cap_w),
    .en_q      (en_w),
    .mode_q    (mode_w),
    .w1c_mask  (w1c_w)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_w),
    .cmp_a_i    (cmp_a_w),
    .cmp_b_i    (cmp_b_w),
    .cap_i      (cap_w),
    .cap_evt_i  (cap_evt),
    .cnt_o      (cnt_o),
    .set_o      (set_w),
    .cap_load_o (cap_load_w)
  );

  tmr_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_w),
    .ack_i   (irq_ack),
    .w1c_i   (w1c_w),
    .en_i    (en_w),
    .flags_o (flags_o),
    .irq_o   (irq_o)
  );

  assign cap_o    = cap_w;
  assign status_o = status_pack(flags_o);

  // R3: compare A flag rises the cycle after the count matches
  a_r3_cmpa_late: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == cmp_a_w) |=> flags_o[F_CMPA]);

  // R3: compare B flag rises the cycle after the count matches
  a_r3_cmpb_late: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == cmp_b_w) |=> flags_o[F_CMPB]);

  // R4: a forced strobe alone leaves a clear compare A flag clear
  a_r4_force_a: assert property (@(posedge clk) disable iff (!rst_n)
    (foc_a && cnt_o != cmp_a_w && !flags_o[F_CMPA]) |=> !flags_o[F_CMPA]);

  // R4: a forced strobe alone leaves a clear compare B flag clear
  a_r4_force_b: assert property (@(posedge clk) disable iff (!rst_n)
    (foc_b && cnt_o != cmp_b_w && !flags_o[F_CMPB]) |=> !flags_o[F_CMPB]);

  // R5: overflow flag follows a wrap from all-ones
  a_r5_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == '1) |=> flags_o[F_OVF]);

  // R6: a capture outside TOP mode copies the count and flags it
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && mode_w != MODE_CLR_CAP) |=> (flags_o[F_CAP] && cap_o == $past(cnt_o)));

  // R7: in TOP mode a capture event leaves the register alone
  a_r7_cap_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && mode_w == MODE_CLR_CAP && !(wr_en && wr_addr == ADDR_CAP)) |=> $stable(cap_o));

  // R7: in TOP mode the capture flag follows the count reaching TOP
  a_r7_top_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MODE_CLR_CAP && cnt_o == cap_w) |=> flags_o[F_CAP]);

endmodule

// File: tb/tb_tmr_flag_unit.sv
`timescale 1ns/1ps
module tb_tmr_flag_unit;

  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         cap_evt = 1'b0;
  logic         foc_a = 1'b0;
  logic         foc_b = 1'b0;
  logic [3:0]   irq_ack = '0;
  logic [W-1:0] cnt_o;
  logic [W-1:0] cap_o;
  logic [3:0]   flags_o;
  logic [7:0]   status_o;
  logic [3:0]   irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  tmr_flag_unit #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_evt(cap_evt), .foc_a(foc_a), .foc_b(foc_b), .irq_ack(irq_ack),
    .cnt_o(cnt_o), .cap_o(cap_o), .flags_o(flags_o), .status_o(status_o), .irq_o(irq_o)
  );

  // Reference state built from the requirements.
  int m_cnt, m_cmpa, m_cmpb, m_cap, m_mode;
  bit [3:0] m_flag, m_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmpa = 0; m_cmpb = 0; m_cap = 0; m_mode = 0; m_flag = 0; m_en = 0;
    end else begin
      bit [3:0] s, c;
      int top, nc;
      s[0] = (m_cnt == MAXV);
      s[1] = (m_cnt == m_cmpb);
      s[2] = (m_cnt == m_cmpa);
      s[3] = (m_mode == 2) ? (m_cnt == m_cap) : cap_evt;
      c = irq_ack;
      if (wr_en && wr_addr == 3) c = c | wr_data[5:2];
      m_flag = (m_flag & ~c) | s;
      top = (m_mode == 1) ? m_cmpa : (m_mode == 2) ? m_cap : MAXV;
      nc = (m_cnt == top) ? 0 : (m_cnt + 1) % (MAXV + 1);
      if (m_mode != 2 && cap_evt) m_cap = m_cnt;
      else if (wr_en && wr_addr == 2) m_cap = wr_data;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_cmpa = wr_data;
          3'd1: m_cmpb = wr_data;
          3'd4: m_en = wr_data[5:2];
          3'd5: m_mode = wr_data[1:0];
          default: ;
        endcase
      end
      m_cnt = nc;
    end
  end

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(cnt_o, m_cnt, "R2 counter");
    check(cap_o, m_cap, "R6 capture register");
    check(flags_o[3], m_flag[3], "R6/R7 capture flag");
    check(flags_o[2], m_flag[2], "R3 compare A flag");
    check(flags_o[1], m_flag[1], "R3 compare B flag");
    check(flags_o[0], m_flag[0], "R5 overflow flag");
    check(status_o, {2'b00, m_flag, 2'b00}, "R11 status layout");
    check(irq_o, m_flag & m_en, "R12 interrupt requests");
  endtask

  // Apply the inputs set by the caller at one posedge, compare at the negedge, then idle them.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    wr_en = 0; cap_evt = 0; foc_a = 0; foc_b = 0; irq_ack = '0;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = a[2:0]; wr_data = d[W-1:0];
    tick();
  endtask

  task automatic wait_cnt(input int v);
    for (int k = 0; k < 600; k++) begin
      if (int'(cnt_o) == v) return;
      tick();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset image
    check(cnt_o, 0, "R1 counter");
    check(cap_o, 0, "R1 capture");
    check(flags_o, 0, "R1 flags");
    check(status_o, 0, "R1 status");
    check(irq_o, 0, "R1 irq");
    rst_n = 1;
    tick();

    wr(4, 8'h3C);
    wr(0, 10);
    wr(1, 200);
    for (int i = 0; i < 300; i++) begin
      foc_a = (i % 7 == 2); foc_b = (i % 11 == 4);
      tick();
    end

    // R8: acknowledge clears every flag
    wait_cnt(5);
    irq_ack = 4'hF; tick();
    check(flags_o, 0, "R8 ack clears all");

    // R10: compare A match together with its acknowledge
    wait_cnt(10);
    irq_ack = 4'b0100; tick();
    check(flags_o[2], 1, "R10 set wins over ack");
    irq_ack = 4'b0100; tick();
    check(flags_o[2], 0, "R8 ack clears compare A");

    // R9: write-one clears only the selected flag
    wait_cnt(MAXV);
    tick();
    check(flags_o[0], 1, "R5 overflow after wrap");
    wr(3, 8'h04);
    check(flags_o[0], 0, "R9 overflow cleared");
    check(flags_o[1], 1, "R9 compare B untouched");

    // R4: forced strobes never set a compare flag
    irq_ack = 4'hF; tick();
    foc_a = 1; foc_b = 1; tick();
    check(flags_o[2:1], 0, "R4 forced compare");

    // Clear on compare A
    wr(0, 20);
    wr(5, 1);
    for (int i = 0; i < 300; i++) begin
      cap_evt = (i % 17 == 3);
      tick();
    end
    irq_ack = 4'hF; tick();
    for (int i = 0; i < 60; i++) tick();
    check(flags_o[0], 0, "R5 no overflow at TOP 20");

    // Capture register as TOP
    wr(2, 50);
    wr(5, 2);
    for (int i = 0; i < 400; i++) begin
      cap_evt = (i % 13 == 5);
      tick();
    end
    check(cap_o, 50, "R7 capture ignored in TOP mode");

    // Random mix of writes, events, strobes and acknowledges
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 10 == 0) begin
        wr_en = 1; wr_addr = 3'($urandom % 6); wr_data = W'($urandom);
      end
      cap_evt = ($urandom % 16 == 0);
      foc_a = ($urandom % 8 == 0);
      foc_b = ($urandom % 8 == 0);
      irq_ack = 4'($urandom) & 4'($urandom) & 4'($urandom);
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule